// File: doc/BRIEF.md
# Capture Configuration Frame Parser

This block takes a stream of 16-bit words from a host link and turns it into the capture settings of a logic-analyzer core. It ignores the stream until it sees a start sync. It then reads a run of self-describing records. Each record is a 16-bit header followed by the number of payload words that header announces. The frame is accepted only when an end sync arrives where the next header would be. Settings are collected in a staging copy. The live outputs change together, in one cycle, and only when a frame closes cleanly.

Each of the two sync patterns is a 32-bit value sent low word first. The start sync is 0xF5A5F5A5, so it arrives as two words of 0xF5A5. The end sync is 0xFA5AFA5A, so it arrives as two words of 0xFA5A. The settings pass through unchanged: the mode word, the clock divider, the capture length in units of 16 samples, the trigger position, the trigger global word and the channel-enable mask. The large trigger table is not stored here. Its words go out one at a time with a running address to a trigger memory further downstream.

Top module: `tlvp_parser`

## Requirements
- R1: After reset every configuration output is zero, and `cfg_commit`, `cfg_err` and `tbl_we` are low.
- R2: While hunting for the start sync, every accepted word other than 0xF5A5 is discarded with no effect on any output. A 0xF5A5 followed by any other word sends the parser back to hunting.
- R3: A header carries a record index in bits 15:8 and a payload length in 16-bit words in bits 7:0. The accepted (index, length) pairs are: mode (0, 1), divider (1, 2), count (3, 2), trigger position (5, 2), trigger global (7, 1), channel enable (8, 1) and trigger table (64, 160).
- R4: A two-word value is assembled with the first payload word as bits 15:0 and the second as bits 31:16.
- R5: The live outputs change only in the cycle after the second end-sync word is accepted, and `cfg_commit` pulses high for exactly that cycle.
- R6: A header with an unknown index, or with a length that does not match its index, pulses `cfg_err` for one cycle after that header is accepted. It also returns the parser to hunting, leaves the live outputs unchanged, and discards every value staged by that frame.
- R7: A first end-sync word followed by any word other than 0xFA5A pulses `cfg_err` and commits nothing.
- R8: Each trigger-table payload word appears on `tbl_data`, with `tbl_we` high and `tbl_addr` counting 0 to 159, in the cycle after it is accepted.
- R9: A word presented while `in_valid` is low has no effect.
- R10: A committed frame that leaves out a record keeps that record's live value from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_word | input | 16 | Incoming stream word |
| cfg_mode | output | 16 | Live mode word |
| cfg_div | output | 32 | Live sample-clock divider |
| cfg_cnt | output | 32 | Live capture length, in units of 16 samples |
| cfg_tpos | output | 32 | Live trigger position |
| cfg_tglb | output | 16 | Live trigger global word |
| cfg_chen | output | 16 | Live channel-enable mask |
| cfg_commit | output | 1 | One-cycle pulse: live outputs were just loaded |
| cfg_err | output | 1 | One-cycle pulse: frame rejected |
| tbl_we | output | 1 | Trigger-table word valid |
| tbl_addr | output | 8 | Trigger-table word address |
| tbl_data | output | 16 | Trigger-table word |

## Verification
The assertions check the properties that hold on every cycle. The live divider and mode move only together with a commit pulse. Commit and error never fire together, and each is a single-cycle pulse. Table addresses stay in range, and a cycle with `in_valid` low produces no strobe in the next cycle. The bench scenarios are needed for the rest: the low-word-first assembly, the exact header table, and the rejection of bad lengths and broken end syncs. They also show that a failed frame's staged values are dropped, and that records left out of a frame keep their old live values.

// File: rtl/tlvp_pkg.sv
package tlvp_pkg;
  localparam logic [15:0] SYNC_OPEN  = 16'hF5A5;
  localparam logic [15:0] SYNC_CLOSE = 16'hFA5A;
  localparam int NREG = 6;

  typedef enum logic [2:0] {SL_MODE, SL_DIV, SL_CNT, SL_TPOS, SL_TGLB, SL_CHEN, SL_TBL} slot_e;
  typedef enum logic [2:0] {ST_HUNT, ST_OPEN2, ST_HDR, ST_PAY, ST_CLOSE2} pst_e;

  function automatic int slot_w(int s);
    return (s == int'(SL_DIV) || s == int'(SL_CNT) || s == int'(SL_TPOS)) ? 32 : 16;
  endfunction

  function automatic int slot_off(int s);
    int o;
    o = 0;
    for (int k = 0; k < s; k++) o += slot_w(k);
    return o;
  endfunction
endpackage

// File: rtl/tlvp_hdr_dec.sv
module tlvp_hdr_dec
  import tlvp_pkg::*;
#(
  parameter int TBL_WORDS = 160
) (
  input  logic [15:0] hdr,
  output logic        known,
  output logic        len_ok,
  output slot_e       slot
);
  logic [7:0] exp_len;

  always_comb begin
    known   = 1'b1;
    slot    = SL_MODE;
    exp_len = 8'd1;
    case (hdr[15:8])
      8'd0:  begin slot = SL_MODE; exp_len = 8'd1; end
      8'd1:  begin slot = SL_DIV;  exp_len = 8'd2; end
      8'd3:  begin slot = SL_CNT;  exp_len = 8'd2; end
      8'd5:  begin slot = SL_TPOS; exp_len = 8'd2; end
      8'd7:  begin slot = SL_TGLB; exp_len = 8'd1; end
      8'd8:  begin slot = SL_CHEN; exp_len = 8'd1; end
      8'd64: begin slot = SL_TBL;  exp_len = 8'(TBL_WORDS); end
      default: known = 1'b0;
    endcase
    len_ok = (hdr[7:0] == exp_len);
  end
endmodule

// File: rtl/tlvp_seq.sv
module tlvp_seq
  import tlvp_pkg::*;
#(
  parameter int TBL_WORDS = 160,
  localparam int AW = $clog2(TBL_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_word,
  input  logic          hdr_known,
  input  logic          hdr_len_ok,
  input  slot_e         hdr_slot,
  output logic          stage_load,
  output logic          pay_we,
  output slot_e         pay_slot,
  output logic          pay_hi,
  output logic          commit_now,
  output logic          commit_q,
  output logic          err_q,
  output logic          tbl_we_q,
  output logic [AW-1:0] tbl_addr_q,
  output logic [15:0]   tbl_data_q
);
  pst_e       st_q, st_n;
  logic [7:0] cnt_q, cnt_n;
  logic [7:0] len_q, len_n;
  slot_e      slot_q, slot_n;
  logic       err_now, tbl_now;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    len_n      = len_q;
    slot_n     = slot_q;
    stage_load = 1'b0;
    pay_we     = 1'b0;
    tbl_now    = 1'b0;
    commit_now = 1'b0;
    err_now    = 1'b0;
    if (in_valid) begin
      case (st_q)
        ST_HUNT:  if (in_word == SYNC_OPEN) st_n = ST_OPEN2;
        ST_OPEN2: begin
          if (in_word == SYNC_OPEN) begin
            st_n       = ST_HDR;
            stage_load = 1'b1;
          end else st_n = ST_HUNT;
        end
        ST_HDR: begin
          if (in_word == SYNC_CLOSE) st_n = ST_CLOSE2;
          else if (hdr_known && hdr_len_ok) begin
            st_n   = ST_PAY;
            slot_n = hdr_slot;
            len_n  = in_word[7:0];
            cnt_n  = 8'd0;
          end else begin
            err_now = 1'b1;
            st_n    = ST_HUNT;
          end
        end
        ST_PAY: begin
          if (slot_q == SL_TBL) tbl_now = 1'b1;
          else pay_we = 1'b1;
          if (cnt_q == len_q - 8'd1) st_n = ST_HDR;
          else cnt_n = cnt_q + 8'd1;
        end
        ST_CLOSE2: begin
          if (in_word == SYNC_CLOSE) commit_now = 1'b1;
          else err_now = 1'b1;
          st_n = ST_HUNT;
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  assign pay_slot = slot_q;
  assign pay_hi   = cnt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HUNT;
      cnt_q    <= '0;
      len_q    <= '0;
      slot_q   <= SL_MODE;
      commit_q <= 1'b0;
      err_q    <= 1'b0;
      tbl_we_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      len_q    <= len_n;
      slot_q   <= slot_n;
      commit_q <= commit_now;
      err_q    <= err_now;
      tbl_we_q <= tbl_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_addr_q <= '0;
      tbl_data_q <= '0;
    end else if (tbl_now) begin
      tbl_addr_q <= cnt_q[AW-1:0];
      tbl_data_q <= in_word;
    end
  end
endmodule

// File: rtl/tlvp_regbank.sv
module tlvp_regbank
  import tlvp_pkg::*;
#(
  localparam int TOTW = slot_off(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stage_load,
  input  logic            pay_we,
  input  slot_e           pay_slot,
  input  logic            pay_hi,
  input  logic [15:0]     in_word,
  input  logic            commit_now,
  output logic [TOTW-1:0] live_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int W   = slot_w(g);
    localparam int OFF = slot_off(g);
    logic [W-1:0] stg_q, live_q;
    logic         wr_en;

    assign wr_en = pay_we && (pay_slot == slot_e'(g));

    if (W == 32) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else if (stage_load) stg_q <= live_q;
        else if (wr_en) begin
          if (pay_hi) stg_q[31:16] <= in_word;
          else        stg_q[15:0]  <= in_word;
        end
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else if (stage_load) stg_q <= live_q;
        else if (wr_en) stg_q <= in_word;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else if (commit_now) live_q <= stg_q;
    end

    assign live_flat[OFF +: W] = live_q;
  end
endmodule

// File: rtl/tlvp_parser.sv
module tlvp_parser
  import tlvp_pkg::*;
#(
  parameter int TBL_WORDS = 160,
  localparam int AW = $clog2(TBL_WORDS),
  localparam int TOTW = slot_off(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_word,
  output logic [15:0]   cfg_mode,
  output logic [31:0]   cfg_div,
  output logic [31:0]   cfg_cnt,
  output logic [31:0]   cfg_tpos,
  output logic [15:0]   cfg_tglb,
  output logic [15:0]   cfg_chen,
  output logic          cfg_commit,
  output logic          cfg_err,
  output logic          tbl_we,
  output logic [AW-1:0] tbl_addr,
  output logic [15:0]   tbl_data
);
  logic            hdr_known, hdr_len_ok;
  slot_e           hdr_slot, pay_slot;
  logic            stage_load, pay_we, pay_hi, commit_now;
  logic [TOTW-1:0] live_flat;

  tlvp_hdr_dec #(.TBL_WORDS(TBL_WORDS)) u_dec (
    .hdr(in_word), .known(hdr_known), .len_ok(hdr_len_ok), .slot(hdr_slot)
  );

  tlvp_seq #(.TBL_WORDS(TBL_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .hdr_known(hdr_known), .hdr_len_ok(hdr_len_ok), .hdr_slot(hdr_slot),
    .stage_load(stage_load), .pay_we(pay_we), .pay_slot(pay_slot), .pay_hi(pay_hi),
    .commit_now(commit_now), .commit_q(cfg_commit), .err_q(cfg_err),
    .tbl_we_q(tbl_we), .tbl_addr_q(tbl_addr), .tbl_data_q(tbl_data)
  );

  tlvp_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .stage_load(stage_load), .pay_we(pay_we),
    .pay_slot(pay_slot), .pay_hi(pay_hi), .in_word(in_word),
    .commit_now(commit_now), .live_flat(live_flat)
  );

  assign cfg_mode = live_flat[slot_off(int'(SL_MODE)) +: 16];
  assign cfg_div  = live_flat[slot_off(int'(SL_DIV))  +: 32];
  assign cfg_cnt  = live_flat[slot_off(int'(SL_CNT))  +: 32];
  assign cfg_tpos = live_flat[slot_off(int'(SL_TPOS)) +: 32];
  assign cfg_tglb = live_flat[slot_off(int'(SL_TGLB)) +: 16];
  assign cfg_chen = live_flat[slot_off(int'(SL_CHEN)) +: 16];
endmodule

// File: rtl/tlvp_parser_chk.sv
module tlvp_parser_chk #(
  parameter int TBL_WORDS = 160,
  localparam int AW = $clog2(TBL_WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [15:0]   cfg_mode,
  input logic [31:0]   cfg_div,
  input logic          cfg_commit,
  input logic          cfg_err,
  input logic          tbl_we,
  input logic [AW-1:0] tbl_addr
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_commit && cfg_err));

  p_div_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div != $past(cfg_div)) |-> cfg_commit);

  p_mode_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != $past(cfg_mode)) |-> cfg_commit);

  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> !cfg_commit);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);

  p_tbl_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (int'(tbl_addr) < TBL_WORDS));

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!cfg_commit && !cfg_err && !tbl_we));
endmodule

bind tlvp_parser tlvp_parser_chk #(.TBL_WORDS(TBL_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_mode(cfg_mode),
  .cfg_div(cfg_div), .cfg_commit(cfg_commit), .cfg_err(cfg_err),
  .tbl_we(tbl_we), .tbl_addr(tbl_addr)
);

// File: tb/tlvp_parser_tb.sv
module tlvp_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid;
  logic [15:0] in_word;
  logic [15:0] cfg_mode, cfg_tglb, cfg_chen, tbl_data;
  logic [31:0] cfg_div, cfg_cnt, cfg_tpos;
  logic        cfg_commit, cfg_err, tbl_we;
  logic [7:0]  tbl_addr;

  tlvp_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cfg_cnt(cfg_cnt), .cfg_tpos(cfg_tpos),
    .cfg_tglb(cfg_tglb), .cfg_chen(cfg_chen), .cfg_commit(cfg_commit), .cfg_err(cfg_err),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  int total = 0, bad = 0, n_commit = 0, n_err = 0, n_tbl = 0;
  bit done = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, keyed by record index
  int          m_st, m_idx, m_len, m_pos;
  logic [31:0] m_live [0:8];
  logic [31:0] m_stg  [0:8];
  logic        e_commit, e_err, e_tbl;
  logic [7:0]  e_addr;
  logic [15:0] e_data;

  function automatic int want_len(int idx);
    case (idx)
      0, 7, 8: return 1;
      1, 3, 5: return 2;
      64:      return 160;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; e_commit = 0; e_err = 0; e_tbl = 0;
      foreach (m_live[i]) begin m_live[i] = 0; m_stg[i] = 0; end
    end else begin
      e_commit = 0; e_err = 0; e_tbl = 0;
      if (in_valid) begin
        case (m_st)
          0: if (in_word == 16'hF5A5) m_st = 1;
          1: if (in_word == 16'hF5A5) begin m_st = 2; m_stg = m_live; end else m_st = 0;
          2: if (in_word == 16'hFA5A) m_st = 4;
             else if (want_len(int'(in_word[15:8])) == int'(in_word[7:0])) begin
               m_idx = int'(in_word[15:8]); m_len = int'(in_word[7:0]); m_pos = 0; m_st = 3;
             end else begin e_err = 1; m_st = 0; end
          3: begin
               if (m_idx == 64) begin e_tbl = 1; e_addr = 8'(m_pos); e_data = in_word; end
               else if (m_pos == 0) m_stg[m_idx][15:0] = in_word;
               else m_stg[m_idx][31:16] = in_word;
               m_pos++;
               if (m_pos == m_len) m_st = 2;
             end
          default: begin
               if (in_word == 16'hFA5A) begin e_commit = 1; m_live = m_stg; end
               else e_err = 1;
               m_st = 0;
             end
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    if (cfg_commit) n_commit++;
    if (cfg_err) n_err++;
    if (tbl_we) n_tbl++;
    chk("R5 commit", {31'd0, cfg_commit}, {31'd0, e_commit});
    chk("R6 err", {31'd0, cfg_err}, {31'd0, e_err});
    chk("R8 tbl_we", {31'd0, tbl_we}, {31'd0, e_tbl});
    if (e_tbl) chk("R8 tbl addr/data", {8'd0, tbl_addr, tbl_data}, {8'd0, e_addr, e_data});
    chk("R5 mode", {16'd0, cfg_mode}, m_live[0]);
    chk("R5 div", cfg_div, m_live[1]);
    chk("R5 cnt", cfg_cnt, m_live[3]);
    chk("R5 tpos", cfg_tpos, m_live[5]);
    chk("R5 tglb", {16'd0, cfg_tglb}, m_live[7]);
    chk("R5 chen", {16'd0, cfg_chen}, m_live[8]);
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk); in_valid = 1; in_word = w;
  endtask
  task automatic idle(input logic [15:0] w);
    @(negedge clk); in_valid = 0; in_word = w;
  endtask
  task automatic opn(); send(16'hF5A5); send(16'hF5A5); endtask
  task automatic cls(); send(16'hFA5A); send(16'hFA5A); endtask
  task automatic settle(); idle(16'h0); idle(16'h0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, e0, t0;
    in_valid = 0; in_word = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 mode", {16'd0, cfg_mode}, 0);
    chk("R1 div", cfg_div, 0);
    chk("R1 strobes", {29'd0, cfg_commit, cfg_err, tbl_we}, 0);
    rst_n = 1;

    // R2: noise while hunting, including a lone open word and close words
    send(16'h1234); send(16'hFA5A); send(16'hF5A5); send(16'h0001);
    send(16'h0001); send(16'h7777); send(16'hFA5A); send(16'hFA5A);
    settle();
    chk("R2 no commit", n_commit, 0);
    chk("R2 no err", n_err, 0);

    // full frame with stalls (R3, R4, R8, R9)
    opn();
    send(16'h0001); idle(16'hFA5A); send(16'hA55A);
    send(16'h0102); send(16'h0001); idle(16'hFFFF); send(16'h0002);
    send(16'h0302); send(16'h5678); send(16'h1234);
    send(16'h0502); send(16'h0040); send(16'h0000);
    send(16'h0701); send(16'h0023);
    send(16'h0801); send(16'h00FF);
    send(16'h40A0);
    for (int i = 0; i < 160; i++) begin
      send(16'h1000 + 16'(i));
      if (i % 37 == 5) idle(16'hF5A5);
    end
    cls(); settle();
    chk("R4 div low first", cfg_div, 32'h0002_0001);
    chk("R4 cnt low first", cfg_cnt, 32'h1234_5678);
    chk("R3 mode", {16'd0, cfg_mode}, 32'h0000_A55A);
    chk("R3 chen", {16'd0, cfg_chen}, 32'h0000_00FF);
    chk("R8 table count", n_tbl, 160);
    chk("R5 one commit", n_commit, 1);

    // R6: unknown index, staged mode must be dropped
    e0 = n_err;
    opn(); send(16'h0001); send(16'hBEEF); send(16'h0201); send(16'h0000);
    settle();
    chk("R6 unknown index err", n_err, e0 + 1);
    chk("R6 mode kept", {16'd0, cfg_mode}, 32'h0000_A55A);

    // R6: known index with wrong length
    e0 = n_err;
    opn(); send(16'h0002); send(16'h1111); send(16'h2222); cls();
    settle();
    chk("R6 bad length err", n_err, e0 + 1);

    // R7: broken close
    e0 = n_err; c0 = n_commit;
    opn(); send(16'h0001); send(16'h3333); send(16'hFA5A); send(16'h0000);
    settle();
    chk("R7 broken close err", n_err, e0 + 1);
    chk("R7 no commit", n_commit, c0);
    chk("R7 mode kept", {16'd0, cfg_mode}, 32'h0000_A55A);

    // R10 + R6 discard: frame with only channel enable
    opn(); send(16'h0801); send(16'h0F0F); cls();
    settle();
    chk("R10 chen new", {16'd0, cfg_chen}, 32'h0000_0F0F);
    chk("R10 mode kept", {16'd0, cfg_mode}, 32'h0000_A55A);
    chk("R10 div kept", cfg_div, 32'h0002_0001);

    // R9: invalid words inside a header slot do nothing
    e0 = n_err; c0 = n_commit; t0 = n_tbl;
    opn(); idle(16'hFFFF); idle(16'hFA5A); idle(16'hFA5A); send(16'h0701); send(16'h0042);
    idle(16'hFA5A); cls(); settle();
    chk("R9 no err", n_err, e0);
    chk("R9 one commit", n_commit, c0 + 1);
    chk("R9 tglb", {16'd0, cfg_tglb}, 32'h0000_0042);
    chk("R9 no table", n_tbl, t0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule